// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a block of words between a memory on a shared bus and one peripheral device, without the processor touching any of the data. The processor programs a memory base address, a word count and a device address through a small register port. It then writes a control word that holds the transfer direction and a go bit, and goes back to its own work. The engine moves one word per bus ownership. The processor therefore loses the bus for a single cycle at a time and does not have to wait for the whole block.

Before each word, the engine waits until the device side can take part. It then raises a bus request and moves the word in the cycle in which the arbiter grants it. After that word it drops the request for at least `MIN_GAP` cycles, so that the processor can win arbitration. The memory address steps by `WORD_STRIDE` after each word and the remaining count falls by one. When the last word has moved, a level interrupt is raised. It stays high until the processor acknowledges it.

Top module: `cycle_dma_engine`

## Requirements
- R1: Out of reset the interrupt, the bus request and every readable register are zero.
- R2: While a transfer is busy, writes to the base (select 0), count (select 1) and device (select 2) registers are ignored. A go write to the control register (select 3, bit 0) is also ignored, and so is the direction it carries. Readback shows the old values and the running transfer keeps its settings.
- R3: Status bit 0 (busy) reads 1 from the cycle after an accepted go until the edge that completes the final word.
- R4: Exactly the programmed number of words move. Word k uses memory address base + k × stride, which wraps modulo the address width. No other memory location is written.
- R5: With control bit 1 clear (memory to device), each word is read from memory and presented on the device write data with its valid high. The memory write enable stays low.
- R6: With control bit 1 set (device to memory), each word is taken from the device read data with its ready high and written to memory with the write enable high.
- R7: The programmed device address is driven on the device address output during every word.
- R8: After each granted word the bus request is low for at least `MIN_GAP` cycles.
- R9: The bus request is raised only while the device side is ready: read valid when the direction is device to memory, write ready when it is memory to device. A word moves only in a cycle where request and grant are both high.
- R10: The interrupt rises on the edge that completes the final word. It stays high until a control write with bit 2 set; a control write without bit 2 leaves it high.
- R11: A go with a word count of zero raises the interrupt on the next edge, leaves busy low and never requests the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 count, 2 device, 3 control/status |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Readback of the selected register (status at select 3: bit0 busy, bit1 irq, bit2 direction) |
| bus_req | output | 1 | Bus request for one word |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the same cycle |
| dev_addr | output | DEV_AW | Selected device address |
| dev_rd_valid | input | 1 | Device has a word to give |
| dev_rd_data | input | DATA_W | Word offered by the device |
| dev_rd_ready | output | 1 | Engine takes the offered word this cycle |
| dev_wr_valid | output | 1 | Engine presents a word to the device this cycle |
| dev_wr_data | output | DATA_W | Word presented to the device |
| dev_wr_ready | input | 1 | Device can accept a word |
| irq | output | 1 | Completion interrupt, held until acknowledged |

## Verification
A go write is sampled on a rising edge, and the request can appear in the very next cycle. A word moves combinationally in the cycle where request and grant coincide. The address step, the dropped request, the falling busy bit and the rising interrupt all appear one edge after that word. The bench drives grant, readiness and device data just after each falling edge and samples half a nanosecond later, so each word and each status change is compared in the cycle it is due. The bench keeps its own word index, per-word address and data pattern, and compares every transfer against them. It sweeps both directions, counts from zero to six, three base addresses (one wrapping) and three stall patterns.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;

   typedef enum logic [1:0] {
      SEL_MEM_BASE = 2'd0,
      SEL_WORDS    = 2'd1,
      SEL_DEVICE   = 2'd2,
      SEL_CTRL     = 2'd3
   } dma_sel_e;

   // control write bits
   localparam int CTRL_GO  = 0;
   localparam int CTRL_DIR = 1;
   localparam int CTRL_ACK = 2;

   // status read bits
   localparam int STAT_BUSY = 0;
   localparam int STAT_IRQ  = 1;
   localparam int STAT_DIR  = 2;
   localparam int STAT_BITS = 3;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_WAIT,
      SQ_GAP
   } sq_state_e;

endpackage

// File: rtl/dma_cmd_regs.sv
`timescale 1ns/1ps
module dma_cmd_regs
   import dma_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8,
   parameter int DEV_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              busy,
   input  logic              done,
   output logic              go,
   output logic              cfg_dir,
   output logic              irq,
   output logic [ADDR_W-1:0] cfg_base,
   output logic [CNT_W-1:0]  cfg_words,
   output logic [DEV_AW-1:0] cfg_dev
);

   dma_sel_e sel;
   logic     cmd_open;
   logic     ctrl_wr;

   assign sel      = dma_sel_e'(reg_sel);
   assign cmd_open = reg_wr && !busy;
   assign ctrl_wr  = reg_wr && (sel == SEL_CTRL);
   assign go       = cmd_open && (sel == SEL_CTRL) && reg_wdata[CTRL_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_base  <= '0;
         cfg_words <= '0;
         cfg_dev   <= '0;
         cfg_dir   <= 1'b0;
         irq       <= 1'b0;
      end else begin
         if (cmd_open && (sel == SEL_MEM_BASE)) cfg_base  <= reg_wdata[ADDR_W-1:0];
         if (cmd_open && (sel == SEL_WORDS))    cfg_words <= reg_wdata[CNT_W-1:0];
         if (cmd_open && (sel == SEL_DEVICE))   cfg_dev   <= reg_wdata[DEV_AW-1:0];
         if (go)                                cfg_dir   <= reg_wdata[CTRL_DIR];
         if (done)
            irq <= 1'b1;
         else if (ctrl_wr && reg_wdata[CTRL_ACK])
            irq <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_MEM_BASE: reg_rdata[ADDR_W-1:0] = cfg_base;
         SEL_WORDS:    reg_rdata[CNT_W-1:0]  = cfg_words;
         SEL_DEVICE:   reg_rdata[DEV_AW-1:0] = cfg_dev;
         default: begin
            reg_rdata[STAT_BUSY] = busy;
            reg_rdata[STAT_IRQ]  = irq;
            reg_rdata[STAT_DIR]  = cfg_dir;
         end
      endcase
   end

endmodule

// File: rtl/dma_walk.sv
`timescale 1ns/1ps
module dma_walk #(
   parameter int ADDR_W      = 16,
   parameter int CNT_W       = 8,
   parameter int WORD_STRIDE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  words,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);

   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(WORD_STRIDE);
   localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         remain <= '0;
      end else if (load) begin
         addr   <= base;
         remain <= words;
      end else if (step) begin
         addr   <= addr + STEP_A;
         remain <= remain - ONE_C;
      end
   end

   assign last = (remain == ONE_C);

endmodule

// File: rtl/dma_seq.sv
`timescale 1ns/1ps
module dma_seq
   import dma_pkg::*;
#(
   parameter int MIN_GAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic no_words,
   input  logic last,
   input  logic dev_ok,
   input  logic bus_gnt,
   output logic busy,
   output logic bus_req,
   output logic move,
   output logic done
);

   sq_state_e state, state_nx;
   logic      gap_done;

   generate
      if (MIN_GAP == 1) begin : g_gap_one
         assign gap_done = 1'b1;
      end else begin : g_gap_count
         localparam int GW = $clog2(MIN_GAP);
         logic [GW-1:0] gap_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               gap_cnt <= '0;
            else if (state != SQ_GAP)
               gap_cnt <= '0;
            else
               gap_cnt <= gap_cnt + GW'(1);
         end
         assign gap_done = (gap_cnt == GW'(MIN_GAP - 1));
      end
   endgenerate

   assign busy    = (state != SQ_IDLE);
   assign bus_req = (state == SQ_WAIT) && dev_ok;
   assign move    = bus_req && bus_gnt;
   assign done    = ((state == SQ_IDLE) && go && no_words) || (move && last);

   always_comb begin
      state_nx = state;
      case (state)
         SQ_IDLE: if (go && !no_words) state_nx = SQ_WAIT;
         SQ_WAIT: if (move)            state_nx = last ? SQ_IDLE : SQ_GAP;
         SQ_GAP:  if (gap_done)        state_nx = SQ_WAIT;
         default:                      state_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SQ_IDLE;
      else        state <= state_nx;
   end

endmodule

// File: rtl/cycle_dma_engine.sv
`timescale 1ns/1ps
module cycle_dma_engine
   import dma_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 8,
   parameter int DEV_AW      = 4,
   parameter int REG_W       = 16,
   parameter int WORD_STRIDE = 1,
   parameter int MIN_GAP     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DEV_AW-1:0] dev_addr,
   input  logic              dev_rd_valid,
   input  logic [DATA_W-1:0] dev_rd_data,
   output logic              dev_rd_ready,
   output logic              dev_wr_valid,
   output logic [DATA_W-1:0] dev_wr_data,
   input  logic              dev_wr_ready,
   output logic              irq
);

   generate
      if (MIN_GAP < 1) begin : g_chk_gap
         $error("MIN_GAP must be at least 1");
      end
      if (REG_W < ADDR_W || REG_W < CNT_W || REG_W < DEV_AW || REG_W < STAT_BITS) begin : g_chk_regw
         $error("REG_W too narrow for the command fields");
      end
      if (WORD_STRIDE < 1) begin : g_chk_stride
         $error("WORD_STRIDE must be at least 1");
      end
      if (DATA_W < 1 || CNT_W < 1 || DEV_AW < 1) begin : g_chk_widths
         $error("widths must be positive");
      end
   endgenerate

   logic              go, cfg_dir, busy, done, move, last, dev_ok, no_words;
   logic [ADDR_W-1:0] cfg_base;
   logic [CNT_W-1:0]  cfg_words;
   logic [DEV_AW-1:0] cfg_dev;

   dma_cmd_regs #(
      .REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_AW(DEV_AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
      .go(go), .cfg_dir(cfg_dir), .irq(irq), .cfg_base(cfg_base),
      .cfg_words(cfg_words), .cfg_dev(cfg_dev)
   );

   dma_walk #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_STRIDE(WORD_STRIDE)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .load(go), .step(move), .base(cfg_base),
      .words(cfg_words), .addr(mem_addr), .last(last)
   );

   assign no_words = (cfg_words == '0);
   assign dev_ok   = cfg_dir ? dev_rd_valid : dev_wr_ready;

   dma_seq #(
      .MIN_GAP(MIN_GAP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .no_words(no_words), .last(last),
      .dev_ok(dev_ok), .bus_gnt(bus_gnt), .busy(busy), .bus_req(bus_req),
      .move(move), .done(done)
   );

   assign mem_we       = move && cfg_dir;
   assign mem_wdata    = dev_rd_data;
   assign dev_rd_ready = move && cfg_dir;
   assign dev_wr_valid = move && !cfg_dir;
   assign dev_wr_data  = mem_rdata;
   assign dev_addr     = cfg_dev;

endmodule

// File: rtl/dma_engine_checker.sv
`timescale 1ns/1ps
module dma_engine_checker #(
   parameter int ADDR_W      = 16,
   parameter int REG_W       = 16,
   parameter int WORD_STRIDE = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_sel,
   input logic [REG_W-1:0]  reg_wdata,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic              dev_rd_valid,
   input logic              dev_rd_ready,
   input logic              dev_wr_valid,
   input logic              dev_wr_ready,
   input logic              irq
);

   logic ack_wr;
   assign ack_wr = reg_wr && (reg_sel == 2'd3) && reg_wdata[2];

   AST_GAP_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt) |=> !bus_req); // R8

   AST_REQ_DEV_READY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (dev_rd_valid || dev_wr_ready)); // R9

   AST_WR_WORD_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      dev_wr_valid |-> (bus_req && bus_gnt && dev_wr_ready && !mem_we)); // R5

   AST_RD_WORD_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rd_ready |-> (bus_req && bus_gnt && dev_rd_valid && mem_we)); // R6

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt) |=> (mem_addr == $past(mem_addr) + ADDR_W'(WORD_STRIDE))); // R4

   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack_wr) |=> irq); // R10

endmodule

bind cycle_dma_engine dma_engine_checker #(
   .ADDR_W(ADDR_W), .REG_W(REG_W), .WORD_STRIDE(WORD_STRIDE)
) u_dma_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
   .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
   .mem_addr(mem_addr), .mem_we(mem_we), .dev_rd_valid(dev_rd_valid),
   .dev_rd_ready(dev_rd_ready), .dev_wr_valid(dev_wr_valid),
   .dev_wr_ready(dev_wr_ready), .irq(irq)
);

// File: tb/test_cycle_dma_engine.sv
`timescale 1ns/1ps
module test_cycle_dma_engine;
   localparam int AW = 8, DW = 8, CW = 4, DAW = 3, RW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_wr;
   logic [1:0]    reg_sel;
   logic [RW-1:0] reg_wdata, reg_rdata;
   logic          bus_req, bus_gnt;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic [DAW-1:0] dev_addr;
   logic          dev_rd_valid, dev_rd_ready, dev_wr_valid, dev_wr_ready;
   logic [DW-1:0] dev_rd_data, dev_wr_data;
   logic          irq;

   logic          gnt_en, dev_rdy_en;
   logic [DW-1:0] mem [0:255];
   int            n_cmp = 0, n_bad = 0, gcyc = 0;

   always #2.5 clk = ~clk;

   assign bus_gnt      = bus_req & gnt_en;
   assign dev_rd_valid = dev_rdy_en;
   assign dev_wr_ready = dev_rdy_en;
   assign mem_rdata    = mem[mem_addr];

   cycle_dma_engine #(
      .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .DEV_AW(DAW), .REG_W(RW),
      .WORD_STRIDE(1), .MIN_GAP(1)
   ) i_cycle_dma_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_addr(dev_addr),
      .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data),
      .dev_rd_ready(dev_rd_ready), .dev_wr_valid(dev_wr_valid),
      .dev_wr_data(dev_wr_data), .dev_wr_ready(dev_wr_ready), .irq(irq)
   );

   function automatic logic [DW-1:0] mem_init(input int a);
      return DW'(a * 5 + 17);
   endfunction

   function automatic logic [DW-1:0] dev_pat(input int k);
      return DW'(k * 13 + 97);
   endfunction

   task automatic check(input string req, input longint act, input longint exp, input string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic write_reg(input int sel, input int val);
      reg_sel   = 2'(sel);
      reg_wdata = RW'(val);
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr  = 1'b0;
      reg_sel = 2'd3;
      #1;
   endtask

   task automatic launch(input bit dir, input int base, input int n, input int dev);
      gnt_en     = 1'b0;
      dev_rdy_en = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
      write_reg(3, 4);
      write_reg(0, base);
      write_reg(1, n);
      write_reg(2, dev);
      write_reg(3, dir ? 3 : 1);
   endtask

   task automatic drain(input bit dir, input int base, input int n, input int dev, input int mode);
      int  seen = 0;
      int  tail = 0;
      bit  prev = 1'b0;
      for (int c = 0; c < 300; c++) begin
         gcyc++;
         gnt_en      = (mode == 1) ? (gcyc % 3 == 0) : 1'b1;
         dev_rdy_en  = (mode == 2) ? (gcyc % 2 == 1) : 1'b1;
         dev_rd_data = dev_pat(seen);
         #0.5;
         check("R3", reg_rdata[0], seen < n, "busy bit");
         check((n == 0) ? "R11" : "R10", irq, seen == n, "irq level");
         if (prev) check("R8", bus_req, 0, "request after word");
         check("R9", bus_req && !dev_rdy_en, 0, "request without device");
         if (n == 0) check("R11", bus_req, 0, "request on empty block");
         prev = 1'b0;
         if (bus_req && bus_gnt) begin
            check("R4", mem_addr, AW'(base + seen), "word address");
            check("R7", dev_addr, dev, "device address");
            if (dir) begin
               check("R6", mem_we, 1, "memory write enable");
               check("R6", dev_rd_ready, 1, "device read ready");
               check("R6", mem_wdata, dev_pat(seen), "memory write data");
               mem[mem_addr] = mem_wdata;
            end else begin
               check("R5", mem_we, 0, "memory write enable");
               check("R5", dev_wr_valid, 1, "device write valid");
               check("R5", dev_wr_data, mem_init(AW'(base + seen)), "device write data");
            end
            seen++;
            prev = 1'b1;
         end
         @(negedge clk);
         #1;
         if (seen >= n) begin
            tail++;
            if (tail > 3) break;
         end
      end
      check("R4", seen, n, "word total");
      if (dir) check("R4", mem[AW'(base + n)], mem_init(AW'(base + n)), "word past block");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R4 watchdog: actual hang expected finish");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
      gnt_en = 1'b0; dev_rdy_en = 1'b0; dev_rd_data = '0;
      for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;

      // R1 reset state
      check("R1", irq, 0, "irq after reset");
      check("R1", bus_req, 0, "request after reset");
      check("R1", reg_rdata, 0, "status after reset");
      reg_sel = 2'd0; #0.5;
      check("R1", reg_rdata, 0, "base after reset");
      reg_sel = 2'd1; #0.5;
      check("R1", reg_rdata, 0, "count after reset");
      reg_sel = 2'd3;
      @(negedge clk); #1;

      // sweep: direction x count x base x stall pattern
      for (int dir = 0; dir < 2; dir++)
         for (int n = 0; n < 7; n++)
            for (int b = 0; b < 3; b++)
               for (int mode = 0; mode < 3; mode++) begin
                  int base = (b == 0) ? 16 : (b == 1) ? 126 : 253;
                  int dev  = (n + b + mode) % 8;
                  launch(dir[0], base, n, dev);
                  drain(dir[0], base, n, dev, mode);
               end

      // R10: interrupt held until acknowledged
      launch(1'b0, 32, 2, 3);
      drain(1'b0, 32, 2, 3, 0);
      repeat (3) begin
         @(negedge clk); #1;
         check("R10", irq, 1, "irq held");
      end
      write_reg(3, 0);
      check("R10", irq, 1, "irq after write without ack");
      write_reg(3, 4);
      check("R10", irq, 0, "irq after ack");
      check("R10", reg_rdata[1], 0, "status irq after ack");

      // R2: command writes ignored while busy
      launch(1'b0, 64, 3, 5);
      write_reg(2, 6);
      write_reg(0, 85);
      write_reg(1, 9);
      write_reg(3, 3);
      reg_sel = 2'd2; #0.5;
      check("R2", reg_rdata, 5, "device readback");
      reg_sel = 2'd0; #0.5;
      check("R2", reg_rdata, 64, "base readback");
      reg_sel = 2'd1; #0.5;
      check("R2", reg_rdata, 3, "count readback");
      reg_sel = 2'd3; #0.5;
      check("R2", reg_rdata[2], 0, "direction readback");
      check("R2", reg_rdata[0], 1, "still busy");
      @(negedge clk); #1;
      drain(1'b0, 64, 3, 5, 0);

      summary();
      $finish;
   end

endmodule